// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM burst access. When a read or write column command arrives, it captures a 9-bit starting column and presents it on the next cycle. On each later clock it moves one location along the burst and stops after the programmed number of beats. The burst either counts upward or follows an interleaved order, and it always wraps inside the aligned block that the burst length defines. In full-page mode the column runs upward through the whole row and wraps modulo 512. It keeps going until a terminate command or a fresh column load cuts it off.

The burst length and order come from a mode input. That input is taken in only while no burst is running, so a burst in progress keeps the setting it started with. The outputs are the current column, a flag that marks the column as valid, and a flag that marks the final beat of a fixed-length burst. All outputs are registered.

Top module: `burst_col_gen`

## Requirements
- R1: After synchronous reset, col_valid and col_last are 0 and col is 0.
- R2: A load sampled on a rising edge makes col equal start_col and sets col_valid=1 on the next cycle. This happens whatever the block is doing at the time.
- R3: Sequential order (mode_ilv=0) with burst length L of 2, 4 or 8 (mode_len codes 1, 2 and 3): beat n has its low log2(L) bits equal to (start low bits + n) mod L. The bits above them keep the start column's value.
- R4: Interleaved order (mode_ilv=1) with L of 2, 4 or 8: beat n has its low log2(L) bits equal to the start low bits XOR n. The upper bits stay fixed.
- R5: Burst length 1 (mode_len code 0) gives one beat. col_last is 1 on that beat.
- R6: col_last is 1 only on beat L-1 of a fixed-length burst. Without a new load, col_valid falls to 0 on the cycle after that beat. col keeps its last value while idle.
- R7: Full page (mode_len code 7) steps col by one modulo 512 on every cycle. col_last never asserts, and mode_ilv has no effect.
- R8: A terminate sampled without a load clears col_valid and col_last on the next cycle. If load and terminate are sampled together, the load wins.
- R9: A load during a burst restarts the sequence from the new start column and counts the burst length again from beat 0.
- R10: mode_len and mode_ilv are captured only on edges where col_valid is 0. Changes made during a burst have no effect on it. Reserved mode_len codes 4, 5 and 6 behave as length 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Column command: capture start_col and begin a burst |
| start_col | input | 9 | Starting column of the burst |
| term | input | 1 | Burst terminate |
| mode_len | input | 3 | Burst length code: 0=1, 1=2, 2=4, 3=8, 7=full page, 4 to 6 act as 1 |
| mode_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col | output | 9 | Current column address |
| col_valid | output | 1 | col holds a beat of a running burst |
| col_last | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
The assertions assume that load and term are known 0 or 1 on every edge after reset. They also assume that mode_len holds a defined 3-bit value. The full-page stepping property takes the latched mode to be stable while col_valid is high, which the mode latch itself guarantees. The stimulus drives every input on the falling edge with known values. It holds load and term low except on chosen cycles, and it places mode changes both in idle gaps and inside running bursts, so that the hold-while-busy rule is exercised without any undefined input.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_RSV4 = 3'd4,
    BL_RSV5 = 3'd5,
    BL_RSV6 = 3'd6,
    BL_PAGE = 3'd7
  } blen_e;

  // Number of low column bits that wrap for a given length code.
  function automatic int unsigned wrap_bits(input blen_e len, input int unsigned colw);
    case (len)
      BL_2:    return 1;
      BL_4:    return 2;
      BL_8:    return 3;
      BL_PAGE: return colw;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_page(input blen_e len);
    return len == BL_PAGE;
  endfunction

endpackage

// File: rtl/bcg_mode_latch.sv
module bcg_mode_latch
  import bcg_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  busy,
  input  logic [2:0] len_in,
  input  logic  ilv_in,
  output blen_e eff_len,
  output logic  eff_ilv
);

  blen_e len_q;
  logic  ilv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= BL_1;
      ilv_q <= 1'b0;
    end else if (!busy) begin
      len_q <= blen_e'(len_in);
      ilv_q <= ilv_in;
    end
  end

  // While idle the live inputs apply to a load on this edge.
  always_comb begin
    if (busy) begin
      eff_len = len_q;
      eff_ilv = ilv_q;
    end else begin
      eff_len = blen_e'(len_in);
      eff_ilv = ilv_in;
    end
  end

  // R10: latched mode frozen while a burst runs
  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(len_q) && $stable(ilv_q)));

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
)(
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  blen_e            len,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  localparam int unsigned WB_W = $clog2(COL_W + 1);

  logic [COL_W-1:0] sum_v;
  logic [COL_W-1:0] xor_v;
  logic [WB_W-1:0]  wb;
  logic             use_xor;

  always_comb begin
    sum_v   = base + beat;
    xor_v   = base ^ beat;
    wb      = WB_W'(wrap_bits(len, COL_W));
    use_xor = ilv && !is_page(len);
  end

  // Each bit either wraps inside the block or keeps the base value.
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (WB_W'(i) < wb)
        addr[i] = use_xor ? xor_v[i] : sum_v[i];
      else
        addr[i] = base[i];
    end
  end

endmodule

// File: rtl/bcg_seq_ctrl.sv
module bcg_seq_ctrl
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             term,
  input  logic [COL_W-1:0] start_col,
  input  blen_e            len,
  input  logic [COL_W-1:0] step_addr,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_nxt,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);

  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] final_beat;
  logic             page;

  always_comb begin
    beat_nxt   = beat_q + 1'b1;
    page       = is_page(len);
    final_beat = COL_W'((1 << wrap_bits(len, COL_W)) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      beat_q    <= '0;
      col       <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (load) begin
      base_q    <= start_col;
      beat_q    <= '0;
      col       <= start_col;
      col_valid <= 1'b1;
      col_last  <= !page && (final_beat == '0);
    end else if (term || col_last) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (col_valid) begin
      beat_q    <= beat_nxt;
      col       <= step_addr;
      col_last  <= !page && (beat_nxt == final_beat);
    end
  end

  // R2: load presents the start column next cycle
  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (col_valid && col == $past(start_col)));

  // R6: last beat is always a valid beat
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R6: burst ends after the last beat
  assert_last_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (col_last && !load) |=> !col_valid);

  // R8: terminate ends the burst
  assert_term_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (term && !load) |=> (!col_valid && !col_last));

  // R7: full page counts upward and never flags a last beat
  assert_page_step_R7: assert property (@(posedge clk) disable iff (rst)
    (col_valid && page && !load && !term) |=> (col == COL_W'($past(col) + 1'b1) && !col_last));

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 9
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic             term,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);

  blen_e            eff_len;
  logic             eff_ilv;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] step_addr;

  bcg_mode_latch u_mode (
    .clk     (clk),
    .rst     (rst),
    .busy    (col_valid),
    .len_in  (mode_len),
    .ilv_in  (mode_ilv),
    .eff_len (eff_len),
    .eff_ilv (eff_ilv)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (base_q),
    .beat (beat_nxt),
    .len  (eff_len),
    .ilv  (eff_ilv),
    .addr (step_addr)
  );

  bcg_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .term      (term),
    .start_col (start_col),
    .len       (eff_len),
    .step_addr (step_addr),
    .base_q    (base_q),
    .beat_nxt  (beat_nxt),
    .col       (col),
    .col_valid (col_valid),
    .col_last  (col_last)
  );

endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [8:0] start_col = '0;
  logic       term = 1'b0;
  logic [2:0] mode_len = '0;
  logic       mode_ilv = 1'b0;
  logic [8:0] col;
  logic       col_valid;
  logic       col_last;

  int errors = 0;
  int checks = 0;
  string req = "R1";

  // reference state
  int  m_col = 0, m_start = 0, m_n = 0, m_beats = 1;
  bit  m_valid = 0, m_last = 0, m_ilv = 0;
  int  m_code = 0;

  always #4 clk = ~clk;

  burst_col_gen dut (
    .clk(clk), .rst(rst), .load(load), .start_col(start_col), .term(term),
    .mode_len(mode_len), .mode_ilv(mode_ilv),
    .col(col), .col_valid(col_valid), .col_last(col_last)
  );

  function automatic int beats_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;   // 0 means full page
      default: return 1;
    endcase
  endfunction

  function automatic int ref_col(int s, int n, int b, bit ilv);
    int lo, base;
    if (b == 0) return (s + n) % 512;
    lo = s % b;
    base = s - lo;
    if (ilv) return base + (lo ^ n);
    return base + ((lo + n) % b);
  endfunction

  always @(posedge clk) begin
    int code_e;
    bit ilv_e;
    if (rst) begin
      m_col = 0; m_valid = 0; m_last = 0; m_code = 0; m_ilv = 0;
    end else begin
      code_e = m_valid ? m_code : int'(mode_len);
      ilv_e  = m_valid ? m_ilv : mode_ilv;
      if (!m_valid) begin m_code = int'(mode_len); m_ilv = mode_ilv; end
      m_beats = beats_of(code_e);
      if (load) begin
        m_start = int'(start_col); m_n = 0; m_col = m_start;
        m_valid = 1; m_last = (m_beats == 1);
      end else if (term || m_last) begin
        m_valid = 0; m_last = 0;
      end else if (m_valid) begin
        m_n++;
        m_col = ref_col(m_start, m_n, m_beats, ilv_e);
        m_last = (m_beats != 0) && (m_n == m_beats - 1);
      end
    end
  end

  task automatic compare();
    checks++;
    if (col !== 9'(m_col) || col_valid !== m_valid || col_last !== m_last) begin
      errors++;
      $display("FAIL %s: col=%0d valid=%0b last=%0b, expected col=%0d valid=%0b last=%0b",
               req, col, col_valid, col_last, m_col, m_valid, m_last);
    end
  endtask

  // one cycle: compare current outputs, then drive the next inputs
  task automatic cyc(bit ld, int sc, bit tm, int ml, bit mi);
    @(negedge clk);
    compare();
    load = ld; start_col = 9'(sc); term = tm; mode_len = 3'(ml); mode_ilv = mi;
  endtask

  task automatic burst(int sc, int ml, bit mi, int idle);
    cyc(1, sc, 0, ml, mi);
    for (int k = 0; k < idle; k++) cyc(0, 0, 0, ml, mi);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    req = "R1";                       // reset state
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    req = "R3";                       // sequential wraps, lengths 2/4/8
    burst(9'h0F3, 1, 0, 4);
    burst(9'h0F3, 2, 0, 6);
    burst(9'h1AD, 3, 0, 10);

    req = "R4";                       // interleaved order
    burst(9'h0F3, 2, 1, 6);
    burst(9'h1AD, 3, 1, 10);
    burst(9'h005, 1, 1, 4);

    req = "R5";                       // single beat
    burst(9'h123, 0, 0, 3);

    req = "R6";                       // back-to-back across last beat
    cyc(1, 9'h040, 0, 2, 0);
    cyc(0, 0, 0, 2, 0);
    cyc(0, 0, 0, 2, 0);
    cyc(0, 0, 0, 2, 0);
    cyc(1, 9'h087, 0, 2, 0);           // load on the last beat
    for (int k = 0; k < 6; k++) cyc(0, 0, 0, 2, 0);

    req = "R7";                       // full page wraps modulo 512
    cyc(1, 9'h1FC, 0, 7, 1);
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 7, 1);
    req = "R8";                       // terminate
    cyc(0, 0, 1, 7, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    req = "R8";                       // load beats terminate
    cyc(1, 9'h030, 0, 3, 0);
    cyc(0, 0, 0, 3, 0);
    cyc(1, 9'h0A2, 1, 3, 0);
    for (int k = 0; k < 3; k++) cyc(0, 0, 0, 3, 0);
    cyc(0, 0, 1, 3, 0);
    cyc(0, 0, 0, 3, 0);
    cyc(0, 0, 0, 3, 0);

    req = "R9";                       // reload mid burst
    cyc(1, 9'h010, 0, 3, 0);
    cyc(0, 0, 0, 3, 0);
    cyc(0, 0, 0, 3, 0);
    cyc(1, 9'h0FE, 0, 3, 0);
    for (int k = 0; k < 10; k++) cyc(0, 0, 0, 3, 0);

    req = "R10";                      // mode change mid burst ignored
    cyc(1, 9'h061, 0, 2, 0);
    cyc(0, 0, 0, 7, 1);
    cyc(0, 0, 0, 0, 1);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 1);
    req = "R10";                      // reserved code acts as one beat
    burst(9'h111, 5, 0, 3);
    burst(9'h0C8, 6, 1, 3);

    cyc(0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule